// File: doc/BRIEF.md
# Coprocessor Access Permission Gate

This block decides whether an instruction aimed at a coprocessor may run. It keeps a 32-bit permission register with one 2-bit code per coprocessor, numbered 0 to 13. Each request carries a coprocessor number and a flag that says whether the core is in user or privileged mode. In the same cycle, the block answers with either an allow or an undefined-instruction exception.

Privileged software reads and writes the register through a simple port. Only the two codes that belong to the floating-point unit, coprocessors 10 and 11, can be written. Every other code is fixed at denied, and the top four bits always read as zero. A write attempted from user mode changes nothing and raises the undefined flag at once. Requests for coprocessor numbers 14 and 15 lie outside the table, so the block raises neither output for them.

Top module: `cp_access_gate`

## Requirements
- R1: After reset, `perm_rd_data` reads 32'h0000_0000, so every coprocessor is denied.
- R2: A privileged write (`perm_wr_en`=1, `perm_wr_user`=0) takes effect one clock later. Bits [21:20] become the code for coprocessor 10 and bits [23:22] become the code for coprocessor 11. Every other bit of `perm_rd_data`, including [31:28], reads 0.
- R3: A write with `perm_wr_user`=1 leaves `perm_rd_data` unchanged, and `perm_wr_undef` is 1 in that same cycle.
- R4: Code 2'b00 gives `req_undef`=1 and `req_allow`=0 in both modes.
- R5: Code 2'b01 gives `req_allow`=1 when `req_user`=0 and `req_undef`=1 when `req_user`=1.
- R6: Code 2'b11 gives `req_allow`=1 in both modes.
- R7: The reserved code 2'b10 gives `req_undef`=1 in both modes.
- R8: A valid request with `req_cp` of 14 or 15 drives neither `req_allow` nor `req_undef`.
- R9: Both outputs are combinational. With `req_valid`=1 and `req_cp` below 14, exactly one of them is 1. With `req_valid`=0, both are 0.
- R10: Coprocessors 0 to 9, 12 and 13 always give `req_undef`, even after all ones have been written to the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| perm_wr_en | input | 1 | Register write strobe |
| perm_wr_user | input | 1 | 1 when the write comes from user mode |
| perm_wr_data | input | 32 | Write data |
| perm_rd_data | output | 32 | Current register contents |
| perm_wr_undef | output | 1 | User-mode write attempt, undefined exception |
| req_valid | input | 1 | A coprocessor instruction is presented |
| req_cp | input | 4 | Target coprocessor number |
| req_user | input | 1 | 1 when the request comes from user mode |
| req_allow | output | 1 | The instruction may proceed |
| req_undef | output | 1 | Raise an undefined-instruction exception |

## Verification
The case that is hardest to reach from the ports is the reserved code 2'b10 held in a writable field. It only exists after a privileged write that places that exact pattern in bits [21:20] or [23:22]. It must then be probed from both modes before anything rewrites it. The vector table therefore pairs each register image (the reserved pattern, all ones, and the single-field codes) with a request that follows it immediately, so every code meets both modes. Directed steps then try a user-mode write of all ones over a known value, and check the readback before any other write happens.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
    localparam int NUM_CP   = 14;
    localparam int FIELD_W  = 2;
    localparam int REG_W    = 32;
    localparam int CP_NUM_W = 4;

    typedef enum logic [FIELD_W-1:0] {
        PERM_DENY = 2'b00,
        PERM_PRIV = 2'b01,
        PERM_RSVD = 2'b10,
        PERM_FULL = 2'b11
    } perm_e;

    typedef struct packed {
        logic [NUM_CP-1:0][FIELD_W-1:0] field;
    } perm_state_t;

    // Grant decision for one code and one mode; reserved and deny refuse.
    function automatic logic perm_grants(input logic [FIELD_W-1:0] code, input logic user);
        case (perm_e'(code))
            PERM_PRIV: perm_grants = !user;
            PERM_FULL: perm_grants = 1'b1;
            default:   perm_grants = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/cpa_perm_reg.sv
module cpa_perm_reg
    import cpa_pkg::*;
#(
    parameter int          N_CP      = NUM_CP,
    parameter int          FW        = FIELD_W,
    parameter int          RW        = REG_W,
    parameter logic [N_CP-1:0] WR_MASK = 14'b00_1100_0000_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_user,
    input  logic [RW-1:0]        wr_data,
    output logic [N_CP*FW-1:0]   fields,
    output logic [RW-1:0]        rd_data,
    output logic                 wr_undef
);
    localparam int FIELD_BITS = N_CP * FW;
    localparam int PAD_W      = RW - FIELD_BITS;

    typedef struct packed {
        logic [N_CP-1:0][FW-1:0] field;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_CP; i++) begin
            if (WR_MASK[i]) begin
                if (wr_en && !wr_user) begin
                    st_d.field[i] = wr_data[i*FW +: FW];
                end
            end else begin
                st_d.field[i] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fields   = st_q;
    assign wr_undef = wr_en && wr_user;

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_data = {{PAD_W{1'b0}}, fields};
        end else begin : g_nopad
            assign rd_data = fields[RW-1:0];
        end
    endgenerate
endmodule

// File: rtl/cpa_perm_check.sv
module cpa_perm_check
    import cpa_pkg::*;
#(
    parameter int N_CP  = NUM_CP,
    parameter int FW    = FIELD_W,
    parameter int NUM_W = CP_NUM_W
) (
    input  logic [N_CP*FW-1:0] fields,
    input  logic               req_valid,
    input  logic [NUM_W-1:0]   req_cp,
    input  logic               req_user,
    output logic               allow,
    output logic               undef
);
    logic [N_CP-1:0] grant;
    logic            in_table;
    logic            sel_grant;

    genvar g;
    generate
        for (g = 0; g < N_CP; g++) begin : g_grant
            assign grant[g] = perm_grants(fields[g*FW +: FW], req_user);
        end
    endgenerate

    always_comb begin
        in_table  = ({{(32-NUM_W){1'b0}}, req_cp} < N_CP);
        sel_grant = 1'b0;
        for (int i = 0; i < N_CP; i++) begin
            if (req_cp == NUM_W'(i)) sel_grant = grant[i];
        end
        allow = req_valid && in_table && sel_grant;
        undef = req_valid && in_table && !sel_grant;
    end
endmodule

// File: rtl/cp_access_gate.sv
module cp_access_gate
    import cpa_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 perm_wr_en,
    input  logic                 perm_wr_user,
    input  logic [REG_W-1:0]     perm_wr_data,
    output logic [REG_W-1:0]     perm_rd_data,
    output logic                 perm_wr_undef,
    input  logic                 req_valid,
    input  logic [CP_NUM_W-1:0]  req_cp,
    input  logic                 req_user,
    output logic                 req_allow,
    output logic                 req_undef
);
    logic [NUM_CP*FIELD_W-1:0] fields;

    cpa_perm_reg #(
        .N_CP (NUM_CP),
        .FW   (FIELD_W),
        .RW   (REG_W)
    ) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (perm_wr_en),
        .wr_user  (perm_wr_user),
        .wr_data  (perm_wr_data),
        .fields   (fields),
        .rd_data  (perm_rd_data),
        .wr_undef (perm_wr_undef)
    );

    cpa_perm_check #(
        .N_CP  (NUM_CP),
        .FW    (FIELD_W),
        .NUM_W (CP_NUM_W)
    ) u_check (
        .fields    (fields),
        .req_valid (req_valid),
        .req_cp    (req_cp),
        .req_user  (req_user),
        .allow     (req_allow),
        .undef     (req_undef)
    );
endmodule

// File: rtl/cp_access_gate_chk.sv
module cp_access_gate_chk
    import cpa_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                perm_wr_en,
    input logic                perm_wr_user,
    input logic [REG_W-1:0]    perm_wr_data,
    input logic [REG_W-1:0]    perm_rd_data,
    input logic                perm_wr_undef,
    input logic                req_valid,
    input logic [CP_NUM_W-1:0] req_cp,
    input logic                req_user,
    input logic                req_allow,
    input logic                req_undef
);
    logic [1:0] fpu_code;
    assign fpu_code = (req_cp == 4'd10) ? perm_rd_data[21:20] : perm_rd_data[23:22];

    assert_fixed_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (perm_rd_data & ~32'h00F0_0000) == 32'h0);

    assert_user_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        perm_wr_en && perm_wr_user |=> perm_rd_data == $past(perm_rd_data));

    assert_user_write_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        perm_wr_en && perm_wr_user |-> perm_wr_undef);

    assert_reserved_denied_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_cp == 4'd10 || req_cp == 4'd11) && fpu_code == 2'b10 |-> req_undef);

    assert_full_allowed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_cp == 4'd10 || req_cp == 4'd11) && fpu_code == 2'b11 |-> req_allow);

    assert_out_of_table_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_cp >= 4'd14 |-> !req_allow && !req_undef);

    assert_single_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_cp < 4'd14 |-> $countones({req_allow, req_undef}) == 1);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !req_allow && !req_undef);

    assert_fixed_cp_denied_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_cp < 4'd14 && req_cp != 4'd10 && req_cp != 4'd11 |-> req_undef);
endmodule

bind cp_access_gate cp_access_gate_chk u_chk (.*);

// File: tb/cp_access_gate_tb.sv
module cp_access_gate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        perm_wr_en = 1'b0;
    logic        perm_wr_user = 1'b0;
    logic [31:0] perm_wr_data = '0;
    logic [31:0] perm_rd_data;
    logic        perm_wr_undef;
    logic        req_valid = 1'b0;
    logic [3:0]  req_cp = '0;
    logic        req_user = 1'b0;
    logic        req_allow;
    logic        req_undef;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    cp_access_gate u_dut (.*);

    typedef struct packed {
        logic [31:0] wdata;
        logic [3:0]  cp;
        logic        user;
        logic        allow;
        logic        undef;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{32'h0050_0000, 4'd10, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 priv
        '{32'h0050_0000, 4'd10, 1'b1, 1'b0, 1'b1, 4'd5},  // R5 user
        '{32'h0040_0000, 4'd11, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 cp11
        '{32'h00F0_0000, 4'd11, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 user
        '{32'h0030_0000, 4'd10, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 cp10 only
        '{32'h00C0_0000, 4'd11, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 priv
        '{32'h00A0_0000, 4'd10, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 priv
        '{32'h00A0_0000, 4'd11, 1'b1, 1'b0, 1'b1, 4'd7},  // R7 user
        '{32'h0000_0000, 4'd10, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 priv
        '{32'h0030_0000, 4'd11, 1'b1, 1'b0, 1'b1, 4'd4},  // R4 user
        '{32'hFFFF_FFFF, 4'd0,  1'b0, 1'b0, 1'b1, 4'd10}, // R10
        '{32'hFFFF_FFFF, 4'd9,  1'b0, 1'b0, 1'b1, 4'd10}, // R10
        '{32'hFFFF_FFFF, 4'd12, 1'b0, 1'b0, 1'b1, 4'd10}, // R10
        '{32'hFFFF_FFFF, 4'd13, 1'b1, 1'b0, 1'b1, 4'd10}, // R10
        '{32'hFFFF_FFFF, 4'd14, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
        '{32'hFFFF_FFFF, 4'd15, 1'b1, 1'b0, 1'b0, 4'd8}   // R8
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] d, input logic user);
        @(negedge clk);
        perm_wr_en   = 1'b1;
        perm_wr_user = user;
        perm_wr_data = d;
        #1;
        check({31'b0, perm_wr_undef}, {31'b0, user}, "R3 wr_undef");
        @(negedge clk);
        perm_wr_en   = 1'b0;
        perm_wr_user = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(perm_rd_data, 32'h0, "R1 reset readback");
        req_valid = 1'b1; req_cp = 4'd10; req_user = 1'b0; #1;
        check({30'b0, req_allow, req_undef}, 32'd1, "R1 reset denies");
        req_valid = 1'b0;

        for (int i = 0; i < NV; i++) begin
            do_write(VECS[i].wdata, 1'b0);
            check(perm_rd_data, VECS[i].wdata & 32'h00F0_0000, "R2 readback");
            req_valid = 1'b1;
            req_cp    = VECS[i].cp;
            req_user  = VECS[i].user;
            #1;
            check({30'b0, req_allow, req_undef}, {30'b0, VECS[i].allow, VECS[i].undef},
                  $sformatf("R%0d vector %0d", VECS[i].req, i));
            @(negedge clk);
            req_valid = 1'b0;
        end

        // R3: user write of all ones over a known value
        do_write(32'h0050_0000, 1'b0);
        do_write(32'hFFFF_FFFF, 1'b1);
        check(perm_rd_data, 32'h0050_0000, "R3 user write ignored");
        req_valid = 1'b1; req_cp = 4'd10; req_user = 1'b1; #1;
        check({30'b0, req_allow, req_undef}, 32'd1, "R3 cp10 still priv-only");

        // R9: idle request gives no answer
        @(negedge clk);
        req_valid = 1'b0; req_cp = 4'd10; req_user = 1'b0; #1;
        check({30'b0, req_allow, req_undef}, 32'd0, "R9 idle");

        // R9: combinational response to mode change in the same cycle
        do_write(32'h00F0_0000, 1'b0);
        req_valid = 1'b1; req_cp = 4'd11; req_user = 1'b1; #1;
        check({30'b0, req_allow, req_undef}, 32'd2, "R9 same-cycle allow");
        req_cp = 4'd3; #1;
        check({30'b0, req_allow, req_undef}, 32'd1, "R9 same-cycle undef");

        // R1: reset clears writable fields
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(perm_rd_data, 32'h0, "R1 reset clears");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule